// File: doc/BRIEF.md
# Prescaled Periodic Down-Counter Timer

This block is a timer peripheral with one down-counter behind a small word-addressed register bus. Software writes a start value, picks a count rate (every clock, every 16th clock or every 256th clock) and picks one of two modes. In periodic mode the counter restarts from the stored start value after it runs out. In free-running mode it wraps to all ones. When the count steps from 1 to 0, a level interrupt goes high. It stays high until software writes the clear register.

Software can read the live count at any time. The counter only moves downward between restarts, so a read that returns a larger value than an earlier read shows that a restart happened in between. Writing zero to the control register parks the timer in a known idle state with the count frozen.

Top module: `pdc_timer`

## Requirements
- R1: After reset, reads of the start-value register (byte offset 0x0), the count register (0x4), the control register (0x8) and the clear register (0xC) all return 0, and `irq_o` is low. Read data appears on `bus_rdata` in the cycle after the cycle in which `bus_rd` is sampled high.
- R2: The control register holds the enable bit (bit 7), the periodic bit (bit 6) and the rate field (bits 3:2). Every other bit reads back as 0. The clear register always reads 0.
- R3: A write to offset 0x0 stores bits 15:0 of the write data as the start value. It also copies that value into the counter at once and restarts the rate divider's phase from zero.
- R4: A write to offset 0x4 sets the counter to bits 15:0 of the write data and leaves the start value unchanged.
- R5: With enable set and rate code 00, the counter takes one step on every clock after the control write. With enable clear, the count holds.
- R6: Rate code 01 gives one step per 16 clocks and rate code 10 gives one per 256 clocks. The first step comes 16 or 256 clocks after the enabling write. Rate code 11 behaves the same as 10.
- R7: A step from count 1 to count 0 sets `irq_o`, and `irq_o` stays high until it is cleared.
- R8: In periodic mode, a step taken at count 0 loads the stored start value.
- R9: In free-running mode, a step taken at count 0 gives 0xFFFF.
- R10: Any write to offset 0xC drops `irq_o` on the next clock. If an expiry occurs in the same cycle, `irq_o` stays high.
- R11: Writing 0 to the control register stops counting. The count holds the value it had after the write's own clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (4) | Byte address; bits 3:2 select the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Level interrupt, held until cleared |

## Verification
The hardest situations to reach from the ports are the ones where two events land on the same clock edge: a clear write arriving just as the counter expires, and a start-value write arriving partway through a divider phase. The stimulus counts clocks exactly from the enabling control write. It puts the clear write on the edge where a count of 1 takes its step, and it rewrites the start value ten clocks into a divide-by-16 phase. It then confirms that the interrupt arrives 16 clocks after that rewrite, not at the original phase boundary. The wrap and reload steps at count 0 are captured by stopping the timer on the very edge that performs the step and then reading the frozen count.

// File: rtl/pdc_timer_pkg.sv
package pdc_timer_pkg;
   localparam int unsigned REG_START = 0;
   localparam int unsigned REG_COUNT = 1;
   localparam int unsigned REG_CTRL  = 2;
   localparam int unsigned REG_CLEAR = 3;

   localparam int unsigned CB_EN  = 7;
   localparam int unsigned CB_PER = 6;
   localparam int unsigned CB_RHI = 3;
   localparam int unsigned CB_RLO = 2;

   typedef enum logic [1:0] {
      RATE_1    = 2'b00,
      RATE_A    = 2'b01,
      RATE_B    = 2'b10,
      RATE_B_AL = 2'b11
   } rate_e;

   typedef struct packed {
      logic  en;
      logic  periodic;
      rate_e rate;
   } ctrl_t;
endpackage

// File: rtl/pdc_timer_prescale.sv
module pdc_timer_prescale
   import pdc_timer_pkg::*;
#(
   parameter int unsigned A_LOG2 = 4,
   parameter int unsigned B_LOG2 = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  en,
   input  rate_e rate,
   input  logic  restart,
   output logic  tick
);
   localparam int unsigned PW = B_LOG2;

   if (A_LOG2 < 1 || A_LOG2 >= B_LOG2) begin : g_bad_div
      $error("pdc_timer_prescale: need 1 <= A_LOG2 < B_LOG2");
   end

   logic [PW-1:0] phase;
   logic [2:0]    hit;

   always_ff @(posedge clk) begin
      if (!rst_n)               phase <= '0;
      else if (restart || !en)  phase <= '0;
      else                      phase <= phase + 1'b1;
   end

   for (genvar g = 0; g < 3; g++) begin : g_hit
      if (g == 0) begin : g_one
         assign hit[g] = 1'b1;
      end else if (g == 1) begin : g_a
         assign hit[g] = &phase[A_LOG2-1:0];
      end else begin : g_b
         assign hit[g] = &phase;
      end
   end

   logic sel_hit;
   always_comb begin
      unique case (rate)
         RATE_1:             sel_hit = hit[0];
         RATE_A:             sel_hit = hit[1];
         RATE_B, RATE_B_AL:  sel_hit = hit[2];
         default:            sel_hit = 1'b0;
      endcase
   end

   assign tick = en && !restart && sel_hit;

   p_tick_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> en);
   p_div_a_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && rate == RATE_A) |=> (phase[A_LOG2-1:0] == '0));
   p_div_b_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && rate[1]) |=> (phase == '0));
endmodule

// File: rtl/pdc_timer_count.sv
module pdc_timer_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             periodic,
   input  logic             start_wr,
   input  logic             count_wr,
   input  logic [CNT_W-1:0] wval,
   input  logic [CNT_W-1:0] start_val,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic any_wr;
   assign any_wr = start_wr || count_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (any_wr) begin
         cnt <= wval;
      end else if (tick) begin
         if (cnt == '0) cnt <= periodic ? start_val : '1;
         else           cnt <= cnt - ONE;
      end
   end

   assign expire = tick && !any_wr && (cnt == ONE);

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !any_wr) |=> $stable(cnt));
   p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !any_wr && !periodic && cnt == '0) |=> (&cnt));
   p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !any_wr && periodic && cnt == '0) |=> (cnt == $past(start_val)));
endmodule

// File: rtl/pdc_timer_regs.sv
module pdc_timer_regs
   import pdc_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              expire,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  start_val,
   output logic              start_wr,
   output logic              count_wr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam logic [DATA_W-1:0] CTRL_MASK =
      (DATA_W'(1) << CB_EN) | (DATA_W'(1) << CB_PER) |
      (DATA_W'(1) << CB_RHI) | (DATA_W'(1) << CB_RLO);

   logic [1:0] idx;
   logic       ctrl_wr, clr_wr;
   assign idx      = bus_addr[3:2];
   assign start_wr = bus_wr && (idx == 2'(REG_START));
   assign count_wr = bus_wr && (idx == 2'(REG_COUNT));
   assign ctrl_wr  = bus_wr && (idx == 2'(REG_CTRL));
   assign clr_wr   = bus_wr && (idx == 2'(REG_CLEAR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl      <= '0;
         start_val <= '0;
      end else begin
         if (ctrl_wr) begin
            ctrl.en       <= bus_wdata[CB_EN];
            ctrl.periodic <= bus_wdata[CB_PER];
            ctrl.rate     <= rate_e'(bus_wdata[CB_RHI:CB_RLO]);
         end
         if (start_wr) start_val <= bus_wdata[CNT_W-1:0];
      end
   end

   logic [DATA_W-1:0] rd_next;
   always_comb begin
      rd_next = '0;
      unique case (idx)
         2'(REG_START): rd_next[CNT_W-1:0] = start_val;
         2'(REG_COUNT): rd_next[CNT_W-1:0] = cnt;
         2'(REG_CTRL): begin
            rd_next[CB_EN]         = ctrl.en;
            rd_next[CB_PER]        = ctrl.periodic;
            rd_next[CB_RHI:CB_RLO] = ctrl.rate;
         end
         default: rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_next;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      irq <= 1'b0;
      else if (expire) irq <= 1'b1;
      else if (clr_wr) irq <= 1'b0;
   end

   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(expire));
   p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !expire) |=> !irq);
   p_irq_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> irq);
   p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && idx == 2'(REG_CTRL)) |=> ((bus_rdata & ~CTRL_MASK) == '0));
endmodule

// File: rtl/pdc_timer.sv
module pdc_timer
   import pdc_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned A_LOG2 = 4,
   parameter int unsigned B_LOG2 = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   if (CNT_W > DATA_W || DATA_W < 8) begin : g_bad_width
      $error("pdc_timer: CNT_W must fit DATA_W, DATA_W >= 8");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("pdc_timer: ADDR_W must be at least 4");
   end

   ctrl_t            ctrl;
   logic [CNT_W-1:0] start_val, cnt;
   logic             start_wr, count_wr, expire, tick;

   pdc_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt), .expire(expire),
      .ctrl(ctrl), .start_val(start_val), .start_wr(start_wr),
      .count_wr(count_wr), .bus_rdata(bus_rdata), .irq(irq_o)
   );

   pdc_timer_prescale #(.A_LOG2(A_LOG2), .B_LOG2(B_LOG2)) pre_i (
      .clk(clk), .rst_n(rst_n), .en(ctrl.en), .rate(ctrl.rate),
      .restart(start_wr), .tick(tick)
   );

   pdc_timer_count #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .periodic(ctrl.periodic),
      .start_wr(start_wr), .count_wr(count_wr),
      .wval(bus_wdata[CNT_W-1:0]), .start_val(start_val),
      .cnt(cnt), .expire(expire)
   );

   p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.en |-> !tick);
   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> (cnt == start_val));
endmodule

// File: tb/pdc_timer_tb_top.sv
module pdc_timer_tb_top;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int n_chk = 0, n_fail = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pdc_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o)
   );

   always @(posedge clk) rd_seen <= bus_rd;

   // monitor: compare each captured read against the scoreboard head
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_chk++;
         if (bus_rdata !== e) begin
            n_fail++;
            $display("FAIL %s: rdata actual=%h expected=%h", t, bus_rdata, e);
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
      bus_rd = 1'b1; bus_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      n_chk++;
      if (irq_o !== e) begin
         n_fail++;
         $display("FAIL %s: irq actual=%b expected=%b", t, irq_o, e);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_irq(1'b0, "R1 reset irq");
      rd(4'h0, 32'h0, "R1 start reg");
      rd(4'h4, 32'h0, "R1 count reg");
      rd(4'h8, 32'h0, "R1 ctrl reg");
      rd(4'hC, 32'h0, "R1 clear reg");

      // R2 control field read-back, reserved bits zero
      wr(4'h8, 32'hFFFF_FF3F);
      rd(4'h8, 32'h0000_000C, "R2 ctrl reserved bits");
      wr(4'h8, 32'h0);

      // R3 start write loads counter
      wr(4'h0, 32'hABCD_0005);
      rd(4'h4, 32'h5, "R3 counter loaded");
      rd(4'h0, 32'h5, "R3 start stored");

      // R5/R7/R8/R11 periodic rate 1
      wr(4'h0, 32'd3);
      wr(4'h8, 32'hC0);
      idle(2);  chk_irq(1'b0, "R5 before expiry");
      idle(1);  chk_irq(1'b1, "R7 expiry 1->0");
      wr(4'h8, 32'h0);
      rd(4'h4, 32'd3, "R8 periodic reload");
      idle(5);
      rd(4'h4, 32'd3, "R11 stopped count holds");
      chk_irq(1'b1, "R7 irq held");
      wr(4'hC, 32'h0);
      chk_irq(1'b0, "R10 clear write");

      // R9 free-running wrap
      wr(4'h0, 32'd2);
      wr(4'h8, 32'h80);
      idle(2);  chk_irq(1'b1, "R9 expiry");
      wr(4'h8, 32'h0);
      rd(4'h4, 32'h0000_FFFF, "R9 wrap to all ones");
      wr(4'hC, 32'h0);

      // R6 divide by 16
      wr(4'h0, 32'd2);
      wr(4'h8, 32'h84);
      idle(31); chk_irq(1'b0, "R6 div16 early");
      idle(1);  chk_irq(1'b1, "R6 div16 expiry");
      wr(4'h8, 32'h0);
      rd(4'h4, 32'h0, "R6 div16 count");
      wr(4'hC, 32'h0);

      // R6 divide by 256
      wr(4'h0, 32'd1);
      wr(4'h8, 32'hC8);
      idle(255); chk_irq(1'b0, "R6 div256 early");
      idle(1);   chk_irq(1'b1, "R6 div256 expiry");
      wr(4'h8, 32'h0);
      wr(4'hC, 32'h0);

      // R6 rate code 11 acts as 10
      wr(4'h0, 32'd1);
      wr(4'h8, 32'h8C);
      rd(4'h8, 32'h8C, "R2 ctrl readback");
      idle(254); chk_irq(1'b0, "R6 code11 early");
      idle(1);   chk_irq(1'b1, "R6 code11 expiry");
      wr(4'h8, 32'h0);
      wr(4'hC, 32'h0);

      // R10 clear and expiry in the same cycle
      chk_irq(1'b0, "R10 precondition");
      wr(4'h0, 32'd1);
      wr(4'h8, 32'h80);
      wr(4'hC, 32'h0);
      chk_irq(1'b1, "R10 expiry beats clear");
      wr(4'h8, 32'h0);
      wr(4'hC, 32'h0);
      chk_irq(1'b0, "R10 later clear");

      // R3 start write restarts divider phase
      wr(4'h0, 32'd1);
      wr(4'h8, 32'h84);
      idle(10);
      wr(4'h0, 32'd1);
      idle(5);  chk_irq(1'b0, "R3 old phase boundary");
      idle(10); chk_irq(1'b0, "R3 restarted phase early");
      idle(1);  chk_irq(1'b1, "R3 restarted phase expiry");
      wr(4'h8, 32'h0);
      wr(4'hC, 32'h0);

      // R4 count write leaves start value
      wr(4'h4, 32'h0000_1234);
      rd(4'h4, 32'h1234, "R4 count written");
      rd(4'h0, 32'h1, "R4 start unchanged");
      rd(4'hC, 32'h0, "R2 clear reads zero");
      idle(20);
      rd(4'h4, 32'h1234, "R5 disabled hold");

      idle(3);
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R1: reads pending actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule